// File: doc/BRIEF.md
# Host-Clocked Serial Read Port with Data-Ready Flag

This block is the read side of a converter's serial interface. The host supplies the serial clock and an active-low frame strobe. During a frame the port shifts out one of three 24-bit sources: the conversion output word, the control word or the calibration word. The source is picked by an address select and a calibration select. An active-low data-ready output tells the host when a fresh conversion result is waiting in the output register.

A one-cycle update strobe, paired with its data, loads new results into the output register. The load is refused while an output read is under way, and that result is lost. Data-ready falls on a load and rises again only when the last bit of the output word has been taken. That last bit is the 16th bit in 16-bit mode and the 24th bit in 24-bit mode. An output read may be split over several frames. An output read attempted while data-ready is high yields no transfer.

The host serial clock and the frame strobe are brought into the system clock domain through two-flop synchronizers. All edges are detected there. The port changes its serial data after each host falling edge, so the host samples on its rising edge.

Top module: `srp_read_port`

## Requirements
- R1: After reset, drdy_n is high and sdata is low. A one-cycle upd_stb, accepted while no output read is in progress, loads upd_data into the output register and drives drdy_n low.
- R2: drdy_n returns high once the host rising edge has taken the last output bit. With word24=1 that is the 24th bit. With word24=0 it is the 16th bit, and the 16-bit word is upd_data[23:8].
- R3: With no read in between, each further update overwrites the output register and drdy_n stays low. A subsequent output read returns the newest word.
- R4: An update that arrives while an output read is in progress is dropped. This holds while a frame is open and also between the frames of a split read. It does not change the output register and does not change drdy_n.
- R5: A frame that opens with addr_sel=1, cal_sel=0 and drdy_n high transfers nothing. sdata stays low, and drdy_n and the read position are unchanged.
- R6: Source selection is as follows. addr_sel=0 selects the control word. addr_sel=1 with cal_sel=1 selects the calibration word. addr_sel=1 with cal_sel=0 selects the output word. Bits leave most significant first. The first bit appears once the frame opens, and each later bit appears after a host falling edge.
- R7: A control or calibration frame always delivers 24 bits, whatever the state of drdy_n, and never changes drdy_n.
- R8: An output read left unfinished when a frame closes resumes in the next output frame at the next unsent bit.
- R9: sdata is low outside an active transfer. This covers no open frame, a refused frame, and any host clock edges after the last bit of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sclk | input | 1 | Serial clock from the host, idle low |
| rd_frame_n | input | 1 | Active-low read frame strobe |
| addr_sel | input | 1 | 1: output or calibration word, 0: control word |
| cal_sel | input | 1 | With addr_sel=1: 1 selects the calibration word |
| word24 | input | 1 | Output word length: 1 = 24 bits, 0 = 16 bits |
| upd_stb | input | 1 | One-cycle strobe carrying a new conversion result |
| upd_data | input | DW | New conversion result |
| ctrl_word | input | DW | Control register contents |
| cal_word | input | DW | Calibration register contents |
| sdata | output | 1 | Serial data, most significant bit first |
| drdy_n | output | 1 | Active-low data-ready flag |

## Verification
The output path is tried in three ways. A single 24-bit frame and a single 16-bit frame separate the two end-of-word rules for when data-ready rises. A read split across frames, with an update injected between its frames, shows whether the read position persists and whether mid-read results are dropped. Repeated updates with no read show whether the newest word wins. Control and calibration frames run with data-ready low, and output frames run with data-ready high. These separate the sources that ignore the flag from the one refused by it, and they check that bits past the 24th read as zero.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_OUT  = 2'd1,
    SRC_CTL  = 2'd2,
    SRC_CAL  = 2'd3
  } src_e;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int W = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/srp_edge.sv
module srp_edge #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/srp_outreg.sv
module srp_outreg #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_stb,
  input  logic [DW-1:0] upd_data,
  input  logic          hold,
  input  logic          done,
  output logic [DW-1:0] word,
  output logic          drdy_n
);
  logic [DW-1:0] word_n;
  logic          drdy_n_n;
  logic          load_en;

  assign load_en = upd_stb & ~hold;

  always_comb begin
    word_n   = word;
    drdy_n_n = drdy_n;
    if (load_en) begin
      word_n   = upd_data;
      drdy_n_n = 1'b0;
    end else if (done) begin
      drdy_n_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word   <= '0;
      drdy_n <= 1'b1;
    end else begin
      word   <= word_n;
      drdy_n <= drdy_n_n;
    end
  end
endmodule

// File: rtl/srp_read_port.sv
module srp_read_port
  import srp_pkg::*;
#(
  parameter int DW = 24,
  parameter int SHORT_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sclk,
  input  logic          rd_frame_n,
  input  logic          addr_sel,
  input  logic          cal_sel,
  input  logic          word24,
  input  logic          upd_stb,
  input  logic [DW-1:0] upd_data,
  input  logic [DW-1:0] ctrl_word,
  input  logic [DW-1:0] cal_word,
  output logic          sdata,
  output logic          drdy_n
);
  localparam int PW = $clog2(DW + 1);
  localparam logic [PW-1:0] REG_LAST  = PW'(DW - 1);
  localparam logic [PW-1:0] LONG_LAST = PW'(DW - 1);
  localparam logic [PW-1:0] SHRT_LAST = PW'(SHORT_W - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // bit 1: serial clock (idle low), bit 0: frame strobe (idle high)
  logic [1:0] lvl_s, rise_v, fall_v;
  srp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .d({host_sclk, rd_frame_n}), .q(lvl_s)
  );
  srp_edge #(.W(2), .RST_VAL(2'b01)) u_edge (
    .clk(clk), .rst_n(rst_n_s), .lvl(lvl_s), .rise(rise_v), .fall(fall_v)
  );

  logic sclk_rise, sclk_fall, frm_open, frm_close;
  assign sclk_rise = rise_v[1];
  assign sclk_fall = fall_v[1];
  assign frm_open  = fall_v[0];
  assign frm_close = rise_v[0];

  src_e          src_q, src_n;
  logic [PW-1:0] optr_q, optr_n, rptr_q, rptr_n;
  logic          sdata_q, sdata_n;
  logic          out_done, out_hold;
  logic [DW-1:0] out_word;
  logic [PW-1:0] out_last;

  assign out_last = word24 ? LONG_LAST : SHRT_LAST;
  assign out_hold = (src_q == SRC_OUT) || (optr_q != '0);

  srp_outreg #(.DW(DW)) u_outreg (
    .clk(clk), .rst_n(rst_n_s), .upd_stb(upd_stb), .upd_data(upd_data),
    .hold(out_hold), .done(out_done), .word(out_word), .drdy_n(drdy_n)
  );

  function automatic logic pick_bit(input src_e s, input logic [DW-1:0] ow,
                                    input logic [DW-1:0] cw, input logic [DW-1:0] kw,
                                    input logic [PW-1:0] op, input logic [PW-1:0] rp);
    logic [DW-1:0] w;
    logic [DW-1:0] sh;
    logic [PW-1:0] p;
    case (s)
      SRC_OUT: begin w = ow; p = op; end
      SRC_CTL: begin w = cw; p = rp; end
      SRC_CAL: begin w = kw; p = rp; end
      default: begin w = '0; p = '0; end
    endcase
    sh = w << p;
    return sh[DW-1];
  endfunction

  always_comb begin
    src_n    = src_q;
    optr_n   = optr_q;
    rptr_n   = rptr_q;
    sdata_n  = sdata_q;
    out_done = 1'b0;
    if (frm_close) begin
      src_n   = SRC_IDLE;
      sdata_n = 1'b0;
    end else if (frm_open) begin
      rptr_n = '0;
      if (!addr_sel)     src_n = SRC_CTL;
      else if (cal_sel)  src_n = SRC_CAL;
      else if (!drdy_n)  src_n = SRC_OUT;
      else               src_n = SRC_IDLE;
      sdata_n = pick_bit(src_n, out_word, ctrl_word, cal_word, optr_q, '0);
    end else if (sclk_rise) begin
      case (src_q)
        SRC_OUT: begin
          if (optr_q == out_last) begin
            optr_n   = '0;
            out_done = 1'b1;
            src_n    = SRC_IDLE;
            sdata_n  = 1'b0;
          end else begin
            optr_n = optr_q + 1'b1;
          end
        end
        SRC_CTL, SRC_CAL: begin
          if (rptr_q == REG_LAST) begin
            rptr_n  = '0;
            src_n   = SRC_IDLE;
            sdata_n = 1'b0;
          end else begin
            rptr_n = rptr_q + 1'b1;
          end
        end
        default: ;
      endcase
    end else if (sclk_fall) begin
      sdata_n = pick_bit(src_q, out_word, ctrl_word, cal_word, optr_q, rptr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      src_q   <= SRC_IDLE;
      optr_q  <= '0;
      rptr_q  <= '0;
      sdata_q <= 1'b0;
    end else begin
      src_q   <= src_n;
      optr_q  <= optr_n;
      rptr_q  <= rptr_n;
      sdata_q <= sdata_n;
    end
  end

  assign sdata = sdata_q;
endmodule

// File: rtl/srp_read_port_chk.sv
module srp_read_port_chk
  import srp_pkg::*;
#(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          upd_stb,
  input logic          drdy_n,
  input logic          sdata,
  input logic          out_done,
  input logic          out_hold,
  input logic [DW-1:0] out_word,
  input src_e          src_q
);
  AST_DRDY_FALLS_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n) |-> $past(upd_stb && !out_hold)); // R1

  AST_DRDY_RISES_ON_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drdy_n) |-> $past(out_done)); // R2

  AST_HOLD_FREEZES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    out_hold |=> $stable(out_word)); // R4

  AST_REG_READ_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (src_q == SRC_OUT)); // R7

  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_IDLE) |-> !sdata); // R9
endmodule

bind srp_read_port srp_read_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .upd_stb(upd_stb), .drdy_n(drdy_n), .sdata(sdata),
  .out_done(out_done), .out_hold(out_hold), .out_word(out_word), .src_q(src_q)
);

// File: tb/tb_srp_read_port.sv
module tb_srp_read_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 80;

  logic        clk = 1'b0;
  logic        rst_n, host_sclk, rd_frame_n, addr_sel, cal_sel, word24, upd_stb;
  logic [23:0] upd_data, ctrl_word, cal_word;
  logic        sdata, drdy_n;

  int vectors = 0;
  int errors  = 0;

  // behavioural reference state
  logic [23:0] m_word, m_rword;
  logic        m_drdy_n;
  int          m_ptr, m_rptr, m_src; // m_src: 0 none, 1 output, 2 register

  always #(CLK_PERIOD/2) clk = ~clk;

  srp_read_port dut (
    .clk(clk), .rst_n(rst_n), .host_sclk(host_sclk), .rd_frame_n(rd_frame_n),
    .addr_sel(addr_sel), .cal_sel(cal_sel), .word24(word24), .upd_stb(upd_stb),
    .upd_data(upd_data), .ctrl_word(ctrl_word), .cal_word(cal_word),
    .sdata(sdata), .drdy_n(drdy_n)
  );

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic model_bit();
    if (m_src == 1) return m_word[23 - m_ptr];
    if (m_src == 2) return m_rword[23 - m_rptr];
    return 1'b0;
  endfunction

  task automatic update(input logic [23:0] d);
    @(negedge clk);
    upd_stb = 1'b1; upd_data = d;
    @(negedge clk);
    upd_stb = 1'b0;
    if (!(m_ptr != 0 || m_src == 1)) begin
      m_word = d; m_drdy_n = 1'b0;
    end
    repeat (2) @(negedge clk);
    check("R1/R3/R4 drdy after update", drdy_n, m_drdy_n);
  endtask

  task automatic frame_open(input logic a, input logic c);
    addr_sel = a; cal_sel = c; rd_frame_n = 1'b0;
    m_rptr = 0;
    if (!a)            begin m_src = 2; m_rword = ctrl_word; end
    else if (c)        begin m_src = 2; m_rword = cal_word; end
    else if (!m_drdy_n) m_src = 1;
    else               m_src = 0;
    #(HALF_SCLK);
  endtask

  task automatic frame_close();
    rd_frame_n = 1'b1;
    m_src = 0;
    #(HALF_SCLK);
    check("R9 sdata low after frame", sdata, 1'b0);
    check("R2/R7/R8 drdy after frame", drdy_n, m_drdy_n);
  endtask

  task automatic host_bits(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      check(req, sdata, model_bit());
      check("R7 drdy during frame", drdy_n, m_drdy_n);
      host_sclk = 1'b1;
      if (m_src == 1) begin
        m_ptr++;
        if (m_ptr == (word24 ? 24 : 16)) begin m_ptr = 0; m_drdy_n = 1'b1; m_src = 0; end
      end else if (m_src == 2) begin
        m_rptr++;
        if (m_rptr == 24) m_src = 0;
      end
      #(HALF_SCLK);
      host_sclk = 1'b0;
      #(HALF_SCLK);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_sclk = 1'b0; rd_frame_n = 1'b1; addr_sel = 1'b1; cal_sel = 1'b0;
    word24 = 1'b1; upd_stb = 1'b0; upd_data = '0;
    ctrl_word = 24'hC3A50F; cal_word = 24'h5A1E87;
    m_word = '0; m_rword = '0; m_drdy_n = 1'b1; m_ptr = 0; m_rptr = 0; m_src = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset drdy", drdy_n, 1'b1);
    check("R1 reset sdata", sdata, 1'b0);

    // R5: output read with drdy high is refused
    frame_open(1'b1, 1'b0);
    host_bits(4, "R5 refused output frame");
    frame_close();

    // R1, R3: two updates, newest wins, 24-bit read (R2, R6)
    update(24'h123456);
    update(24'hB7E15A);
    frame_open(1'b1, 1'b0);
    host_bits(24, "R6 output word 24-bit");
    host_bits(2, "R9 bits after last");
    frame_close();

    // R2: 16-bit mode ends on the 16th bit
    word24 = 1'b0;
    update(24'h9F3C71);
    frame_open(1'b1, 1'b0);
    host_bits(16, "R2 output word 16-bit");
    frame_close();
    word24 = 1'b1;

    // R8 split read with R4 update between frames
    update(24'hE4D2A9);
    frame_open(1'b1, 1'b0);
    host_bits(10, "R8 first part");
    frame_close();
    update(24'h0F0F0F);
    frame_open(1'b1, 1'b0);
    host_bits(14, "R8 second part");
    frame_close();
    frame_open(1'b1, 1'b0);
    host_bits(3, "R4 lost word not readable");
    frame_close();

    // R4 update during an open output frame
    update(24'h6B8D2E);
    frame_open(1'b1, 1'b0);
    host_bits(5, "R4 mid-frame part");
    update(24'hFFFFFF);
    host_bits(19, "R4 word unchanged mid-read");
    frame_close();

    // R7 register reads ignore and keep drdy (low here)
    update(24'h3CC3A5);
    frame_open(1'b0, 1'b0);
    host_bits(24, "R7 control word");
    host_bits(2, "R9 past control word");
    frame_close();
    frame_open(1'b1, 1'b1);
    host_bits(24, "R7 calibration word");
    frame_close();
    frame_open(1'b1, 1'b0);
    host_bits(24, "R6 output after register reads");
    frame_close();

    // R7 register read with drdy high
    frame_open(1'b0, 1'b0);
    host_bits(24, "R7 control word drdy high");
    frame_close();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule